// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time and Over-Current Latch

This block converts register-level switch requests for two half-bridge legs into four gate-enable signals for an external H-bridge. In full-bridge mode it accepts only the four legal bridge patterns and, while the PWM input is low, maps the bridge into a freewheeling state chosen by two configuration bits. In dual half-bridge mode each leg simply follows its own request pair.

Each leg runs a small state machine that puts a programmable dead time in front of every switch turn-on. The dead time for a turn-on of a high side and the dead time for a turn-on of a low side have separate 4-bit codes. Per-switch over-current comparators, arriving as digital inputs, are only looked at while the switch is on and must persist for a filter time before a latched flag trips. The flag shuts down the affected leg in half-bridge mode, or the whole bridge in full-bridge mode, until software clears it. A drivers-allowed input from the mode supervisor forces every gate off at once.

Leg states: `LEG_OFF` (both switches off), `LEG_WAIT_HI` (dead time before the high side turns on), `LEG_HIGH`, `LEG_WAIT_LO` (dead time before the low side turns on), `LEG_LOW`. Transitions: an OFF command takes any state to `LEG_OFF` in one cycle. A HIGH command takes `LEG_OFF`, `LEG_LOW` or `LEG_WAIT_LO` to `LEG_WAIT_HI`, and a LOW command takes `LEG_OFF`, `LEG_HIGH` or `LEG_WAIT_HI` to `LEG_WAIT_LO`; each of these loads the dead-time counter. `LEG_WAIT_HI` moves to `LEG_HIGH`, and `LEG_WAIT_LO` to `LEG_LOW`, when the counter reaches zero.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: After reset all four gates are off and all four over-current flags are clear.
- R2: In half-bridge mode (`half_mode`=1) each leg decodes its pair {req_hs,req_ls}: 10 turns the high side on, 01 turns the low side on, and 00 or 11 turns both off. `pwm_in`, `fw_high` and `fw_active` have no effect in this mode.
- R3: A high-side gate and a low-side gate of the same leg are never on in the same cycle, and neither turns on in the cycle after its partner was on.
- R4: A switch turn-on waits (code+1)×DT_STEP_CYC cycles. A high-side turn-on uses `dt_lh_code` and a low-side turn-on uses `dt_hl_code`. The code is taken when the wait starts, so the gate rises (code+1)×DT_STEP_CYC+1 clock edges after the command changes.
- R5: In full-bridge mode with `pwm_in`=1 the legal patterns are: leg A high with leg B low, leg A low with leg B high, both low, and both high. These are driven as requested. Any pattern in which a leg decodes to off turns all four gates off.
- R6: In full-bridge mode with a legal pattern, `pwm_in`=0 and `fw_high`=1, every low side turns off. If `fw_active`=1 those legs turn their high side on; if `fw_active`=0 they stay open. High sides already requested stay on.
- R7: In full-bridge mode with a legal pattern, `pwm_in`=0 and `fw_high`=0, every high side turns off. If `fw_active`=1 those legs turn their low side on; if `fw_active`=0 they stay open. Low sides already requested stay on.
- R8: While `drv_allow` is 0 all gates are off in the same cycle, with no dead-time wait. The leg state machines are in `LEG_OFF` one clock edge later.
- R9: A switch's over-current flag sets only after its comparator has been high on OC_FILT_CYC consecutive edges while that switch's gate was on. Comparator activity while the gate is off, and shorter pulses, are ignored. Bit order of `oc_cmp`, `oc_clr` and `oc_flag` is: bit 0 leg A low side, bit 1 leg A high side, bit 2 leg B low side, bit 3 leg B high side.
- R10: A set flag stays set until its `oc_clr` bit is pulsed. While any affected flag is set, the gates it disables are off from the cycle after the flag rises.
- R11: In full-bridge mode any set flag turns off the whole bridge. In half-bridge mode a flag turns off only its own leg.
- R12: A one-cycle `oc_clr` pulse clears the flag on the next edge. The leg then resumes its request through the normal dead-time wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_allow | input | 1 | Drivers permitted by mode supervisor |
| half_mode | input | 1 | 1 = two independent half bridges, 0 = full bridge |
| pwm_in | input | 1 | PWM input; low selects freewheeling in full-bridge mode |
| fw_high | input | 1 | Freewheel through high sides (1) or low sides (0) |
| fw_active | input | 1 | Active (1) or passive (0) freewheeling |
| req_hs | input | 2 | High-side request per leg (bit 0 leg A) |
| req_ls | input | 2 | Low-side request per leg (bit 0 leg A) |
| dt_lh_code | input | 4 | Dead-time code before a high-side turn-on |
| dt_hl_code | input | 4 | Dead-time code before a low-side turn-on |
| oc_cmp | input | 4 | Over-current comparator outputs, per switch |
| oc_clr | input | 4 | Flag clear pulses, per switch |
| gate_hs | output | 2 | High-side gate enables (bit 0 leg A) |
| gate_ls | output | 2 | Low-side gate enables (bit 0 leg A) |
| oc_flag | output | 4 | Latched over-current flags, per switch |

## Verification
The assertions assume that every input is synchronous to `clk`, that each `oc_clr` bit is a single-cycle pulse, and that the comparator inputs are only meaningful relative to the gate state this block drives. The stimulus changes all inputs on the falling clock edge and pulses clears for exactly one cycle. Before it clears a flag it drops the matching comparator, so a clear is never raced by a fresh trip. Dead-time codes are changed only while a leg is settled, which keeps the measured wait tied to a single code.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    localparam int LEGS = 2;

    typedef enum logic [1:0] {
        CMD_OFF  = 2'd0,
        CMD_LOW  = 2'd1,
        CMD_HIGH = 2'd2
    } leg_cmd_t;

    typedef enum logic [2:0] {
        LEG_OFF     = 3'd0,
        LEG_WAIT_HI = 3'd1,
        LEG_HIGH    = 3'd2,
        LEG_WAIT_LO = 3'd3,
        LEG_LOW     = 3'd4
    } leg_state_t;

    function automatic leg_cmd_t decode_pair(input logic hs, input logic ls);
        leg_cmd_t r;
        case ({hs, ls})
            2'b10:   r = CMD_HIGH;
            2'b01:   r = CMD_LOW;
            default: r = CMD_OFF;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hbg_cmd_map.sv
module hbg_cmd_map
    import hbg_pkg::*;
(
    input  logic                 half_mode,
    input  logic                 pwm_in,
    input  logic                 fw_high,
    input  logic                 fw_active,
    input  logic                 drv_allow,
    input  logic [LEGS-1:0]      req_hs,
    input  logic [LEGS-1:0]      req_ls,
    input  logic [LEGS-1:0]      leg_kill,
    output leg_cmd_t             leg_cmd [LEGS]
);

    leg_cmd_t raw   [LEGS];
    leg_cmd_t mapped[LEGS];
    logic     bridge_ok;

    always_comb begin
        for (int i = 0; i < LEGS; i++) begin
            raw[i] = decode_pair(req_hs[i], req_ls[i]);
        end
        bridge_ok = (raw[0] != CMD_OFF) && (raw[1] != CMD_OFF);
        for (int i = 0; i < LEGS; i++) begin
            if (half_mode) begin
                mapped[i] = raw[i];
            end else if (!bridge_ok) begin
                mapped[i] = CMD_OFF;
            end else if (pwm_in) begin
                mapped[i] = raw[i];
            end else if (fw_high) begin
                if (raw[i] == CMD_LOW) mapped[i] = fw_active ? CMD_HIGH : CMD_OFF;
                else                   mapped[i] = raw[i];
            end else begin
                if (raw[i] == CMD_HIGH) mapped[i] = fw_active ? CMD_LOW : CMD_OFF;
                else                    mapped[i] = raw[i];
            end
            if (!drv_allow || leg_kill[i]) begin
                leg_cmd[i] = CMD_OFF;
            end else begin
                leg_cmd[i] = mapped[i];
            end
        end
    end

endmodule

// File: rtl/hbg_leg_fsm.sv
module hbg_leg_fsm
    import hbg_pkg::*;
#(
    parameter int DT_STEP_CYC = 62,
    parameter int DT_CODE_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  leg_cmd_t             cmd,
    input  logic [DT_CODE_W-1:0] dt_lh_code,
    input  logic [DT_CODE_W-1:0] dt_hl_code,
    output logic                 hs_on,
    output logic                 ls_on
);

    localparam int CNT_MAX = (2 ** DT_CODE_W) * DT_STEP_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);

    leg_state_t       state_q, state_d;
    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    lh_len, hl_len;
    logic             load_lh, load_hl, dec;

    assign lh_len = CW'((int'(dt_lh_code) + 1) * DT_STEP_CYC - 1);
    assign hl_len = CW'((int'(dt_hl_code) + 1) * DT_STEP_CYC - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LEG_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (load_lh) cnt_q <= lh_len;
        else if (load_hl) cnt_q <= hl_len;
        else if (dec)     cnt_q <= cnt_q - 1'b1;
    end

    always_comb begin
        state_d = state_q;
        load_lh = 1'b0;
        load_hl = 1'b0;
        dec     = 1'b0;
        unique case (state_q)
            LEG_OFF: begin
                if (cmd == CMD_HIGH) begin
                    state_d = LEG_WAIT_HI; load_lh = 1'b1;
                end else if (cmd == CMD_LOW) begin
                    state_d = LEG_WAIT_LO; load_hl = 1'b1;
                end
            end
            LEG_WAIT_HI: begin
                if (cmd == CMD_OFF) begin
                    state_d = LEG_OFF;
                end else if (cmd == CMD_LOW) begin
                    state_d = LEG_WAIT_LO; load_hl = 1'b1;
                end else if (cnt_q == '0) begin
                    state_d = LEG_HIGH;
                end else begin
                    dec = 1'b1;
                end
            end
            LEG_HIGH: begin
                if (cmd == CMD_OFF) begin
                    state_d = LEG_OFF;
                end else if (cmd == CMD_LOW) begin
                    state_d = LEG_WAIT_LO; load_hl = 1'b1;
                end
            end
            LEG_WAIT_LO: begin
                if (cmd == CMD_OFF) begin
                    state_d = LEG_OFF;
                end else if (cmd == CMD_HIGH) begin
                    state_d = LEG_WAIT_HI; load_lh = 1'b1;
                end else if (cnt_q == '0) begin
                    state_d = LEG_LOW;
                end else begin
                    dec = 1'b1;
                end
            end
            LEG_LOW: begin
                if (cmd == CMD_OFF) begin
                    state_d = LEG_OFF;
                end else if (cmd == CMD_HIGH) begin
                    state_d = LEG_WAIT_HI; load_lh = 1'b1;
                end
            end
            default: state_d = LEG_OFF;
        endcase
    end

    always_comb begin
        hs_on = 1'b0;
        ls_on = 1'b0;
        unique case (state_q)
            LEG_HIGH: hs_on = 1'b1;
            LEG_LOW:  ls_on = 1'b1;
            default: begin
                hs_on = 1'b0;
                ls_on = 1'b0;
            end
        endcase
    end

    // R3
    hs_then_no_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_on |=> !ls_on);
    // R3
    ls_then_no_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_on |=> !hs_on);

endmodule

// File: rtl/hbg_oc_guard.sv
module hbg_oc_guard #(
    parameter int OC_FILT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp,
    input  logic sw_on,
    input  logic clr,
    output logic flag
);

    localparam int FW = $clog2(OC_FILT_CYC + 1);

    logic [FW-1:0] cnt_q;
    logic          flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (clr) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (cmp && sw_on) begin
            if (cnt_q == FW'(OC_FILT_CYC - 1)) flag_q <= 1'b1;
            else                              cnt_q  <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    assign flag = flag_q;

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag);
    // R9
    masked_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_on |=> !$rose(flag));

endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int DT_STEP_CYC = 62,
    parameter int DT_CODE_W   = 4,
    parameter int OC_FILT_CYC = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 drv_allow,
    input  logic                 half_mode,
    input  logic                 pwm_in,
    input  logic                 fw_high,
    input  logic                 fw_active,
    input  logic [1:0]           req_hs,
    input  logic [1:0]           req_ls,
    input  logic [DT_CODE_W-1:0] dt_lh_code,
    input  logic [DT_CODE_W-1:0] dt_hl_code,
    input  logic [3:0]           oc_cmp,
    input  logic [3:0]           oc_clr,
    output logic [1:0]           gate_hs,
    output logic [1:0]           gate_ls,
    output logic [3:0]           oc_flag
);

    localparam int NSW = 2 * LEGS;

    leg_cmd_t         leg_cmd [LEGS];
    logic [LEGS-1:0]  leg_hs_q, leg_ls_q;
    logic [LEGS-1:0]  leg_kill;
    logic [NSW-1:0]   sw_on;
    logic [NSW-1:0]   flags;

    always_comb begin
        for (int i = 0; i < LEGS; i++) begin
            if (half_mode) leg_kill[i] = flags[2*i] | flags[2*i+1];
            else           leg_kill[i] = |flags;
        end
    end

    hbg_cmd_map u_map (
        .half_mode (half_mode),
        .pwm_in    (pwm_in),
        .fw_high   (fw_high),
        .fw_active (fw_active),
        .drv_allow (drv_allow),
        .req_hs    (req_hs),
        .req_ls    (req_ls),
        .leg_kill  (leg_kill),
        .leg_cmd   (leg_cmd)
    );

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        hbg_leg_fsm #(
            .DT_STEP_CYC (DT_STEP_CYC),
            .DT_CODE_W   (DT_CODE_W)
        ) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd        (leg_cmd[g]),
            .dt_lh_code (dt_lh_code),
            .dt_hl_code (dt_hl_code),
            .hs_on      (leg_hs_q[g]),
            .ls_on      (leg_ls_q[g])
        );
        assign gate_hs[g]   = leg_hs_q[g] & drv_allow;
        assign gate_ls[g]   = leg_ls_q[g] & drv_allow;
        assign sw_on[2*g]   = gate_ls[g];
        assign sw_on[2*g+1] = gate_hs[g];
    end

    for (genvar s = 0; s < NSW; s++) begin : g_oc
        hbg_oc_guard #(
            .OC_FILT_CYC (OC_FILT_CYC)
        ) u_guard (
            .clk   (clk),
            .rst_n (rst_n),
            .cmp   (oc_cmp[s]),
            .sw_on (sw_on[s]),
            .clr   (oc_clr[s]),
            .flag  (flags[s])
        );
    end

    assign oc_flag = flags;

    logic pattern_legal;
    assign pattern_legal = (req_hs[0] ^ req_ls[0]) && (req_hs[1] ^ req_ls[1]);

    // R8
    allow_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_allow |=> (leg_hs_q == '0) && (leg_ls_q == '0));
    // R5
    illegal_full_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !half_mode && !pattern_legal |=> (leg_hs_q == '0) && (leg_ls_q == '0));
    // R11
    full_oc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|oc_flag) && !half_mode |=> (gate_hs == '0) && (gate_ls == '0));

endmodule

// File: tb/sim_hbridge_gate_ctrl.sv
module sim_hbridge_gate_ctrl;

    localparam int STEP = 62;
    localparam int FILT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       drv_allow = 1'b0, half_mode = 1'b1, pwm_in = 1'b1;
    logic       fw_high = 1'b0, fw_active = 1'b0;
    logic [1:0] req_hs = '0, req_ls = '0;
    logic [3:0] dt_lh_code = '0, dt_hl_code = '0;
    logic [3:0] oc_cmp = '0, oc_clr = '0;
    logic [1:0] gate_hs, gate_ls;
    logic [3:0] oc_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hbridge_gate_ctrl #(.DT_STEP_CYC(STEP), .DT_CODE_W(4), .OC_FILT_CYC(FILT)) u0 (
        .clk(clk), .rst_n(rst_n), .drv_allow(drv_allow), .half_mode(half_mode),
        .pwm_in(pwm_in), .fw_high(fw_high), .fw_active(fw_active),
        .req_hs(req_hs), .req_ls(req_ls), .dt_lh_code(dt_lh_code), .dt_hl_code(dt_hl_code),
        .oc_cmp(oc_cmp), .oc_clr(oc_clr), .gate_hs(gate_hs), .gate_ls(gate_ls),
        .oc_flag(oc_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic measure(input bit hi, input int leg, output int n);
        n = 0;
        while (((hi ? gate_hs[leg] : gate_ls[leg]) == 1'b0) && n < 3000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (gate_hs[leg] && gate_ls[leg]) chk("R3 overlap", 1, 0);
            if (n == 1) chk("R3 partner off", hi ? gate_ls[leg] : gate_hs[leg], 0);
        end
    endtask

    task automatic t_reset();
        cyc(3);
        chk("R1 gates in reset", {gate_hs, gate_ls}, 0);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 gates after reset", {gate_hs, gate_ls}, 0);
        chk("R1 flags after reset", oc_flag, 0);
        drv_allow = 1'b1;
    endtask

    task automatic t_half_decode();
        half_mode = 1'b1;
        req_hs = 2'b01; req_ls = 2'b10;
        cyc(200);
        chk("R2 half hs", gate_hs, 2'b01);
        chk("R2 half ls", gate_ls, 2'b10);
        req_hs = 2'b01; req_ls = 2'b01;
        cyc(3);
        chk("R2 pair 11 off", {gate_hs[0], gate_ls[0]}, 0);
        req_hs = 2'b00; req_ls = 2'b00;
        cyc(3);
        chk("R2 pair 00 off", {gate_hs, gate_ls}, 0);
    endtask

    task automatic t_half_ignores_pwm();
        half_mode = 1'b1;
        req_hs = 2'b01; req_ls = 2'b10;
        cyc(200);
        pwm_in = 1'b0; fw_high = 1'b1; fw_active = 1'b1;
        cyc(200);
        chk("R2 pwm ignored hs", gate_hs, 2'b01);
        chk("R2 pwm ignored ls", gate_ls, 2'b10);
        fw_high = 1'b0;
        cyc(200);
        chk("R2 fw ignored ls", gate_ls, 2'b10);
        pwm_in = 1'b1; fw_active = 1'b0;
    endtask

    task automatic t_deadtime();
        int n;
        half_mode = 1'b1;
        dt_lh_code = 4'd0; dt_hl_code = 4'd0;
        req_hs = 2'b00; req_ls = 2'b01;
        cyc(200);
        dt_lh_code = 4'd5;
        req_hs = 2'b01; req_ls = 2'b00;
        measure(1'b1, 0, n);
        chk("R4 lh code 5", n, 6 * STEP + 1);
        dt_hl_code = 4'd15;
        req_hs = 2'b00; req_ls = 2'b01;
        measure(1'b0, 0, n);
        chk("R4 hl code 15", n, 16 * STEP + 1);
        dt_lh_code = 4'd0; dt_hl_code = 4'd0;
        req_hs = 2'b01; req_ls = 2'b00;
        measure(1'b1, 0, n);
        chk("R4 lh code 0", n, STEP + 1);
    endtask

    task automatic t_full_legal();
        half_mode = 1'b0; pwm_in = 1'b1;
        req_hs = 2'b01; req_ls = 2'b10; cyc(200);
        chk("R5 diag A", {gate_hs, gate_ls}, {2'b01, 2'b10});
        req_hs = 2'b10; req_ls = 2'b01; cyc(200);
        chk("R5 diag B", {gate_hs, gate_ls}, {2'b10, 2'b01});
        req_hs = 2'b00; req_ls = 2'b11; cyc(200);
        chk("R5 both low", {gate_hs, gate_ls}, {2'b00, 2'b11});
        req_hs = 2'b11; req_ls = 2'b00; cyc(200);
        chk("R5 both high", {gate_hs, gate_ls}, {2'b11, 2'b00});
    endtask

    task automatic t_full_illegal();
        half_mode = 1'b0; pwm_in = 1'b1;
        req_hs = 2'b01; req_ls = 2'b00; cyc(200);
        chk("R5 one leg off", {gate_hs, gate_ls}, 0);
        req_hs = 2'b01; req_ls = 2'b11; cyc(200);
        chk("R5 pair 11", {gate_hs, gate_ls}, 0);
    endtask

    task automatic t_freewheel();
        half_mode = 1'b0;
        req_hs = 2'b01; req_ls = 2'b10;
        pwm_in = 1'b0; fw_high = 1'b1; fw_active = 1'b1; cyc(200);
        chk("R6 active high fw", {gate_hs, gate_ls}, {2'b11, 2'b00});
        fw_active = 1'b0; cyc(200);
        chk("R6 passive high fw", {gate_hs, gate_ls}, {2'b01, 2'b00});
        fw_high = 1'b0; fw_active = 1'b1; cyc(200);
        chk("R7 active low fw", {gate_hs, gate_ls}, {2'b00, 2'b11});
        fw_active = 1'b0; cyc(200);
        chk("R7 passive low fw", {gate_hs, gate_ls}, {2'b00, 2'b10});
        pwm_in = 1'b1; cyc(200);
        chk("R5 pwm high restores", {gate_hs, gate_ls}, {2'b01, 2'b10});
    endtask

    task automatic t_drv_allow();
        int n;
        half_mode = 1'b0; pwm_in = 1'b1;
        req_hs = 2'b01; req_ls = 2'b10; cyc(200);
        drv_allow = 1'b0;
        #1;
        chk("R8 immediate off", {gate_hs, gate_ls}, 0);
        cyc(10);
        chk("R8 stays off", {gate_hs, gate_ls}, 0);
        drv_allow = 1'b1;
        measure(1'b1, 0, n);
        chk("R8 resume via dead time", n, STEP + 1);
    endtask

    task automatic t_oc_half();
        int n;
        half_mode = 1'b1;
        req_hs = 2'b01; req_ls = 2'b10; cyc(200);
        oc_cmp = 4'b0010; cyc(FILT - 1);
        oc_cmp = 4'b0000; cyc(2);
        chk("R9 short pulse no trip", oc_flag, 0);
        oc_cmp = 4'b0001; cyc(3 * FILT);
        chk("R9 masked while off", oc_flag, 0);
        oc_cmp = 4'b0010; cyc(FILT - 1);
        chk("R9 not yet tripped", oc_flag, 0);
        cyc(1);
        chk("R9 tripped after filter", oc_flag, 4'b0010);
        cyc(1);
        chk("R10 leg A off", {gate_hs[0], gate_ls[0]}, 0);
        chk("R11 half leg B kept", gate_ls[1], 1);
        oc_cmp = 4'b0000; cyc(50);
        chk("R10 flag latched", oc_flag, 4'b0010);
        chk("R10 still off", gate_hs[0], 0);
        oc_clr = 4'b0010; cyc(1);
        oc_clr = 4'b0000;
        chk("R12 cleared", oc_flag, 0);
        measure(1'b1, 0, n);
        chk("R12 resume", n, STEP + 1);
    endtask

    task automatic t_oc_full();
        half_mode = 1'b0; pwm_in = 1'b1;
        req_hs = 2'b01; req_ls = 2'b10; cyc(200);
        oc_cmp = 4'b0100; cyc(FILT + 1);
        chk("R11 full trip flag", oc_flag, 4'b0100);
        chk("R11 whole bridge off", {gate_hs, gate_ls}, 0);
        oc_cmp = 4'b0000;
        oc_clr = 4'b0100; cyc(1);
        oc_clr = 4'b0000;
        cyc(200);
        chk("R12 full resumes", {gate_hs, gate_ls}, {2'b01, 2'b10});
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_half_decode();
        t_half_ignores_pwm();
        t_deadtime();
        t_full_legal();
        t_full_illegal();
        t_freewheel();
        t_drv_allow();
        t_oc_half();
        t_oc_full();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

endmodule